// File: doc/BRIEF.md
# Single-Instruction Hardware Repeat Controller

This block runs the one single-word instruction that follows a repeat command several times with no loop overhead. A start pulse selects where the iteration count comes from. It is either a 6-bit immediate field or the 16-bit operand bus. When an accumulator drives the bus with its extension bits in use, the value is clamped first. The block then saves the 13-bit loop counter into a temporary register and loads the new count. For every iteration it raises an execute strobe while it holds instruction fetch, so the held word is fetched only once. It masks interrupts for the whole loop, and on the last iteration it writes the saved counter back.

A zero count skips the held instruction. The same happens when decode reports that the follower is illegal (multi-word, flow-changing, or another repeat), and in that case the block also raises an error flag. While the block is idle, the processor can write the loop counter through a plain write port.

Top module: `rep_ctrl`

## Requirements
- R1: With `src_bus_i`=0 the count is the 6-bit `imm_i` zero-extended to 13 bits, so counter bits 12..6 are zero.
- R2: With `src_bus_i`=1 and `ext_used_i`=0 the count is `bus_i[12:0]`, and bits 15..13 are discarded.
- R3: With `src_bus_i`=1 and `ext_used_i`=1 the bus is replaced by its limit value before truncation: `ext_neg_i`=0 gives 0x7FFF (count 8191), and `ext_neg_i`=1 gives 0x8000 (count 0).
- R4: For a nonzero count N, `exec_en_o` is high for exactly N consecutive cycles, starting the cycle after the start edge. During those cycles `lc_o` reads N, N-1, ..., 1.
- R5: `hold_fetch_o`, `irq_mask_o` and `busy_o` are high in exactly the cycles where `exec_en_o` is high.
- R6: A count of zero produces no execute cycle. `busy_o` stays low and `lc_o` keeps its prior value.
- R7: After the loop ends, `lc_o` again holds the value it had just before the start edge.
- R8: A start pulse while `busy_o` is high is ignored. The running loop keeps its count and its saved value.
- R9: If `follower_bad_i` is high at an accepted start, `err_o` is high from the next cycle on, nothing executes and `lc_o` is unchanged. The next accepted legal start clears `err_o`.
- R10: `lc_wr_i` loads `lc_wdata_i` into the counter when the block is idle and no start is present. During a loop it is ignored.
- R11: Synchronous active-high `rst` gives idle, `lc_o`=0, `err_o`=0 and all strobes low.
- R12: A count of one gives exactly one execute cycle and then an immediate restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Repeat command pulse |
| src_bus_i | input | 1 | Count source: 0 immediate, 1 bus |
| imm_i | input | 6 | Immediate count field |
| bus_i | input | 16 | Operand bus count source |
| ext_used_i | input | 1 | Accumulator extension bits in use |
| ext_neg_i | input | 1 | Sign of the accumulator when extended |
| follower_bad_i | input | 1 | Decode reports illegal follower |
| lc_wr_i | input | 1 | Counter write strobe |
| lc_wdata_i | input | 13 | Counter write data |
| busy_o | output | 1 | Loop in progress |
| hold_fetch_o | output | 1 | Freeze instruction fetch |
| exec_en_o | output | 1 | Execute held instruction this cycle |
| irq_mask_o | output | 1 | Block interrupts |
| err_o | output | 1 | Illegal follower seen at last start |
| lc_o | output | 13 | Current loop counter |

## Verification
On every cycle the assertions check the following: the count formatting for the immediate and clamped sources, the one-step decrement while looping, that a zero count leaves the block idle with the counter stable, that starts and writes during a loop are ignored, and that fetch hold and interrupt mask cover every execute strobe. Only the bench scenarios can show that the counter returns to the exact value it had before the loop, that the number of execute strobes matches each count (including the 8191 clamp), and that the error flag is set and then cleared across separate commands.

// File: rtl/rep_pkg.sv
package rep_pkg;
    localparam int LC_W  = 13;
    localparam int IMM_W = 6;
    localparam int BUS_W = 16;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} rep_state_e;

    typedef struct packed {
        logic             use_bus;
        logic [IMM_W-1:0] imm;
        logic [BUS_W-1:0] bus;
        logic             ext_used;
        logic             ext_neg;
    } cnt_src_t;

    // Clamp an extended accumulator to the largest positive or negative bus word.
    function automatic logic [BUS_W-1:0] limit_word(input logic [BUS_W-1:0] w,
                                                    input logic ext_used,
                                                    input logic ext_neg);
        logic [BUS_W-1:0] r;
        if (!ext_used)   r = w;
        else if (ext_neg) r = {1'b1, {(BUS_W-1){1'b0}}};
        else              r = {1'b0, {(BUS_W-1){1'b1}}};
        return r;
    endfunction
endpackage

// File: rtl/rep_count_sel.sv
module rep_count_sel
    import rep_pkg::*;
(
    input  cnt_src_t        src_i,
    output logic [LC_W-1:0] cnt_o
);
    logic [BUS_W-1:0] lim_w;

    always_comb begin
        lim_w = limit_word(src_i.bus, src_i.ext_used, src_i.ext_neg);
        if (src_i.use_bus) cnt_o = lim_w[LC_W-1:0];
        else               cnt_o = {{(LC_W-IMM_W){1'b0}}, src_i.imm};
    end

    always_comb begin
        if (!src_i.use_bus)
            assert_imm_upper_clear_R1: assert (cnt_o[LC_W-1:IMM_W] == '0);
        if (src_i.use_bus && src_i.ext_used && src_i.ext_neg)
            assert_neg_limit_zero_R3: assert (cnt_o == '0);
        if (src_i.use_bus && src_i.ext_used && !src_i.ext_neg)
            assert_pos_limit_max_R3: assert (&cnt_o);
    end
endmodule

// File: rtl/rep_seq.sv
module rep_seq
    import rep_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [LC_W-1:0] cnt_i,
    input  logic            bad_i,
    input  logic            wr_i,
    input  logic [LC_W-1:0] wdata_i,
    output logic            run_o,
    output logic            err_o,
    output logic [LC_W-1:0] lc_o
);
    localparam logic [LC_W-1:0] ONE = LC_W'(1);

    rep_state_e      state_q;
    logic [LC_W-1:0] lc_q;
    logic [LC_W-1:0] save_q;
    logic            err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lc_q    <= '0;
            save_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        save_q <= lc_q;
                        err_q  <= bad_i;
                        if (!bad_i && cnt_i != '0) begin
                            lc_q    <= cnt_i;
                            state_q <= ST_RUN;
                        end
                    end else if (wr_i) begin
                        lc_q <= wdata_i;
                    end
                end
                ST_RUN: begin
                    if (lc_q <= ONE) begin
                        lc_q    <= save_q;
                        state_q <= ST_IDLE;
                    end else begin
                        lc_q <= lc_q - ONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign run_o = (state_q == ST_RUN);
    assign err_o = err_q;
    assign lc_o  = lc_q;

    assert_decrement_R4: assert property (@(posedge clk) disable iff (rst)
        (run_o && lc_q > ONE) |=> (run_o && lc_q == $past(lc_q) - ONE));
    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (run_o && start_i && lc_q > ONE) |=> (lc_q == $past(lc_q) - ONE));
    assert_zero_skip_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_o && start_i && !bad_i && cnt_i == '0) |=> (!run_o && $stable(lc_q)));
    assert_bad_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (!run_o && start_i && bad_i) |=> (err_o && !run_o && $stable(lc_q)));
    assert_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (run_o && wr_i && lc_q > ONE) |=> (lc_q == $past(lc_q) - ONE));
endmodule

// File: rtl/rep_ctrl.sv
module rep_ctrl
    import rep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             src_bus_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [BUS_W-1:0] bus_i,
    input  logic             ext_used_i,
    input  logic             ext_neg_i,
    input  logic             follower_bad_i,
    input  logic             lc_wr_i,
    input  logic [LC_W-1:0]  lc_wdata_i,
    output logic             busy_o,
    output logic             hold_fetch_o,
    output logic             exec_en_o,
    output logic             irq_mask_o,
    output logic             err_o,
    output logic [LC_W-1:0]  lc_o
);
    cnt_src_t        src;
    logic [LC_W-1:0] cnt;
    logic            run;

    assign src = '{use_bus: src_bus_i, imm: imm_i, bus: bus_i,
                   ext_used: ext_used_i, ext_neg: ext_neg_i};

    rep_count_sel u_count_sel (
        .src_i (src),
        .cnt_o (cnt)
    );

    rep_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cnt_i   (cnt),
        .bad_i   (follower_bad_i),
        .wr_i    (lc_wr_i),
        .wdata_i (lc_wdata_i),
        .run_o   (run),
        .err_o   (err_o),
        .lc_o    (lc_o)
    );

    assign busy_o       = run;
    assign hold_fetch_o = run;
    assign exec_en_o    = run;
    assign irq_mask_o   = run;

    assert_exec_masked_R5: assert property (@(posedge clk) disable iff (rst)
        exec_en_o |-> (hold_fetch_o && irq_mask_o && busy_o));
    assert_exec_count_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        exec_en_o |-> (lc_o != '0));
endmodule

// File: tb/test_rep_ctrl.sv
`timescale 1ns/1ps
module test_rep_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, src_bus_i, ext_used_i, ext_neg_i, follower_bad_i, lc_wr_i;
    logic [5:0]  imm_i;
    logic [15:0] bus_i;
    logic [12:0] lc_wdata_i;
    logic        busy_o, hold_fetch_o, exec_en_o, irq_mask_o, err_o;
    logic [12:0] lc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rep_ctrl i_rep_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .src_bus_i(src_bus_i),
        .imm_i(imm_i), .bus_i(bus_i), .ext_used_i(ext_used_i), .ext_neg_i(ext_neg_i),
        .follower_bad_i(follower_bad_i), .lc_wr_i(lc_wr_i), .lc_wdata_i(lc_wdata_i),
        .busy_o(busy_o), .hold_fetch_o(hold_fetch_o), .exec_en_o(exec_en_o),
        .irq_mask_o(irq_mask_o), .err_o(err_o), .lc_o(lc_o)
    );

    typedef struct packed {
        logic        use_bus;
        logic [5:0]  imm;
        logic [15:0] bus;
        logic        ext;
        logic        neg;
        logic [12:0] exp_cnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd5,  16'hFFFF, 1'b0, 1'b0, 13'd5},    // R1
        '{1'b0, 6'd63, 16'h0000, 1'b1, 1'b0, 13'd63},   // R1 (ext ignored on immediate)
        '{1'b1, 6'd9,  16'hE007, 1'b0, 1'b0, 13'd7},    // R2
        '{1'b1, 6'd0,  16'h0001, 1'b0, 1'b0, 13'd1},    // R12
        '{1'b1, 6'd0,  16'h1234, 1'b1, 1'b0, 13'd8191}, // R3 positive clamp
        '{1'b1, 6'd0,  16'h7FFF, 1'b1, 1'b1, 13'd0},    // R3 negative clamp
        '{1'b1, 6'd0,  16'h2000, 1'b0, 1'b0, 13'd0},    // R6 via R2 truncation
        '{1'b0, 6'd0,  16'h0003, 1'b0, 1'b0, 13'd0}     // R6 immediate zero
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_lc(input logic [12:0] v);
        lc_wr_i = 1'b1; lc_wdata_i = v;
        @(negedge clk);
        lc_wr_i = 1'b0;
    endtask

    // Issue a start and return once the start edge has passed.
    task automatic issue(input vec_t v, input bit bad);
        start_i = 1'b1; src_bus_i = v.use_bus; imm_i = v.imm; bus_i = v.bus;
        ext_used_i = v.ext; ext_neg_i = v.neg; follower_bad_i = bad;
        @(negedge clk);
        start_i = 1'b0; follower_bad_i = 1'b0;
    endtask

    // Count execute cycles; check the counter trace and the mask/hold strobes.
    task automatic run_loop(input int n, output int execs, output bit trace_ok, output bit mask_ok);
        execs = 0; trace_ok = 1'b1; mask_ok = 1'b1;
        while (exec_en_o && execs < 9000) begin
            if (lc_o != 13'(n - execs)) trace_ok = 1'b0;
            if (!(hold_fetch_o && irq_mask_o && busy_o)) mask_ok = 1'b0;
            execs++;
            @(negedge clk);
        end
        if (hold_fetch_o || irq_mask_o || busy_o) mask_ok = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int  ex;
        bit  tr, mk;
        rst = 1'b1; start_i = 0; src_bus_i = 0; imm_i = 0; bus_i = 0;
        ext_used_i = 0; ext_neg_i = 0; follower_bad_i = 0; lc_wr_i = 0; lc_wdata_i = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(lc_o == 0, "R11 lc", lc_o, 0);
        chk(!busy_o && !exec_en_o && !hold_fetch_o && !irq_mask_o, "R11 strobes", busy_o, 0);
        chk(err_o == 0, "R11 err", err_o, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [12:0] pre;
            pre = 13'h0A5 + 13'(i * 37);
            write_lc(pre);
            chk(lc_o == pre, "R10 write idle", lc_o, pre);
            issue(VECS[i], 1'b0);
            if (VECS[i].exp_cnt == 0) begin
                chk(!busy_o && !exec_en_o, "R6 no exec", exec_en_o, 0);
                chk(lc_o == pre, "R6 lc kept", lc_o, pre);
            end else begin
                chk(lc_o == VECS[i].exp_cnt, "R1 R2 R3 count load", lc_o, VECS[i].exp_cnt);
                run_loop(VECS[i].exp_cnt, ex, tr, mk);
                chk(ex == VECS[i].exp_cnt, "R4 R12 exec count", ex, VECS[i].exp_cnt);
                chk(tr, "R4 counter trace", tr, 1);
                chk(mk, "R5 hold and mask", mk, 1);
                chk(lc_o == pre, "R7 restore", lc_o, pre);
            end
        end

        // R8 and R10: start and write during a loop are ignored
        write_lc(13'd300);
        issue('{1'b0, 6'd10, 16'h0, 1'b0, 1'b0, 13'd10}, 1'b0);
        @(negedge clk); @(negedge clk);
        start_i = 1'b1; src_bus_i = 1'b0; imm_i = 6'd2; lc_wr_i = 1'b1; lc_wdata_i = 13'd77;
        @(negedge clk);
        start_i = 1'b0; lc_wr_i = 1'b0;
        chk(lc_o == 13'd7, "R8 R10 loop continues", lc_o, 7);
        run_loop(7, ex, tr, mk);
        chk(ex == 7, "R8 remaining execs", ex, 7);
        chk(lc_o == 13'd300, "R8 R7 restore original", lc_o, 300);

        // R9 illegal follower
        write_lc(13'd55);
        issue('{1'b0, 6'd4, 16'h0, 1'b0, 1'b0, 13'd4}, 1'b1);
        chk(err_o == 1'b1, "R9 err set", err_o, 1);
        chk(!exec_en_o && !busy_o, "R9 no exec", exec_en_o, 0);
        chk(lc_o == 13'd55, "R9 lc kept", lc_o, 55);
        @(negedge clk);
        chk(err_o == 1'b1, "R9 err holds", err_o, 1);
        issue('{1'b0, 6'd2, 16'h0, 1'b0, 1'b0, 13'd2}, 1'b0);
        chk(err_o == 1'b0, "R9 err cleared", err_o, 0);
        run_loop(2, ex, tr, mk);
        chk(ex == 2 && lc_o == 13'd55, "R9 R7 legal run", ex, 2);

        // R11 reset mid-loop
        issue('{1'b0, 6'd20, 16'h0, 1'b0, 1'b0, 13'd20}, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && lc_o == 0 && err_o == 0, "R11 reset mid-loop", lc_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule